// File: doc/BRIEF.md
# Prescaled Match and Capture Timer

A counter core for a peripheral timer. A programmable prescaler sits in front of a CW-bit counter. In one mode the prescaler steps once per clock. In the other modes it steps on the rising edge, the falling edge or both edges of one chosen capture input. When the prescaler wraps, the counter advances.

Four match channels compare their value against the counter on every advance. On a hit, each channel can do any of the following, each enabled on its own: return the counter to zero, stop it, set a flag and drive an external output bit. Four capture channels sample the counter on chosen edges of their own inputs.

Software reaches the block through a plain write port: a write enable, a 4-bit address and a data word. The counter, the capture values, the output bits, the flags and the interrupt line are brought straight out as ports.

The address map is:

| Address | Contents |
|---|---|
| 0 | Control: bit0 = run, bit1 = hold |
| 1 | Mode: bits[1:0] = count source, bits[3:2] = selected input |
| 2 | Prescale value |
| 3 | Match actions: channel i uses bit 3i = flag enable, bit 3i+1 = reset on match, bit 3i+2 = stop on match |
| 4 | Output control: bits[2i+1:2i] = action for channel i; bits[11:8] = value loaded into the four output bits |
| 5 | Capture control: channel i uses bits[3i+1:3i] = edge code and bit 3i+2 = interrupt enable |
| 6 | Flags, write one to clear |
| 8 to 11 | Match values for channels 0 to 3 |

Top module: `pmc_timer`

## Requirements
- R1: After reset the counter, all capture values, the flags, the output bits and irq are 0, and the counter is stopped.
- R2: While hold (address 0, bit1) is set, the counter and the prescale count are held at 0. While run (address 0, bit0) is clear, the counter keeps its value.
- R3: With count source 0 and run set, the counter advances once every (prescale value + 1) clock cycles. It wraps to 0 only through a match reset or overflow.
- R4: With count source 1, 2 or 3, one count event is the rising, falling or either edge of cap_in[selected input], seen after a two-flop synchronizer. The clock alone then counts nothing.
- R5: A match happens when the counter advances while it equals a channel's match value. With reset on match enabled, the counter's next value is 0 instead of value+1.
- R6: With stop on match enabled, a match clears run, and the counter keeps the matched value.
- R7: Every match sets flag bit i (bits 0 to 3), whatever its enables are. irq is the OR of all flags ANDed with their enables (address 3 bit 3i for match channels, address 5 bit 3i+2 for capture channels).
- R8: Writing address 6 clears each flag whose data bit is 1. Flag bits 0 to 3 belong to the match channels and bits 4 to 7 to the capture channels. Data bits of 0 leave the flags unchanged.
- R9: Output action codes are 0 none, 1 drive 0, 2 drive 1, 3 toggle; each acts on a match of its channel. Writing address 4 loads bits[11:8] into the output bits.
- R10: Capture edge codes are 0 off, 1 rising, 2 falling, 3 both. A selected edge on cap_in[i] copies the counter into capture value i and sets flag bit 4+i. With code 0, edges are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | CW | Write data |
| cap_in | input | 4 | Capture and count inputs, asynchronous |
| count | output | CW | Timer counter |
| cap_val | output | 4*CW | Capture values, channel i at bits [i*CW +: CW] |
| match_out | output | 4 | External match bits |
| flags | output | 8 | Match flags [3:0], capture flags [7:4] |
| irq | output | 1 | Interrupt request |

## Verification
The checker assumes that writes are the only source of control changes. It also assumes the hold bit is the only way besides an advance to move the counter, and that the flag register is written only through address 6. The bench keeps to this: it changes configuration only while the counter is held or stopped. The one exception is the run bit itself.

The bench holds each level on cap_in for four clocks or more, so every edge passes the synchronizer once. Captures are checked against a counter that was frozen beforehand by a stop on match, which makes every expected capture value exact.

// File: rtl/pmc_timer.sv
module pmc_timer #(
  parameter int CW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [3:0]      wr_addr,
  input  logic [CW-1:0]   wr_data,
  input  logic [3:0]      cap_in,
  output logic [CW-1:0]   count,
  output logic [4*CW-1:0] cap_val,
  output logic [3:0]      match_out,
  output logic [7:0]      flags,
  output logic            irq
);
  localparam int NCH = 4;

  logic          run, hold;
  logic [1:0]    mode, sel;
  logic [CW-1:0] psc, pc;
  logic [11:0]   mctl, cctl;
  logic [7:0]    oact;
  logic [CW-1:0] mr [NCH];
  logic [NCH-1:0] s1, s2, s3, rise, fall, mhit, cap_hit, rst_en, stop_en;
  logic ev, tick, do_rst, do_stop;
  logic [7:0] clr, ien;

  wire wr_ctl  = wr_en && wr_addr == 4'd0;
  wire wr_ext  = wr_en && wr_addr == 4'd4;
  wire wr_flag = wr_en && wr_addr == 4'd6;

  assign rise = s2 & ~s3;
  assign fall = ~s2 & s3;

  always_comb begin
    case (mode)
      2'd0:    ev = run;
      2'd1:    ev = run & rise[sel];
      2'd2:    ev = run & fall[sel];
      default: ev = run & (rise[sel] | fall[sel]);
    endcase
  end

  assign tick    = ev && (pc == psc);
  assign do_rst  = |(mhit & rst_en);
  assign do_stop = |(mhit & stop_en);
  assign clr     = wr_flag ? wr_data[7:0] : 8'd0;
  assign irq     = |(flags & ien);

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign rst_en[i]  = mctl[3*i+1];
    assign stop_en[i] = mctl[3*i+2];
    assign ien[i]     = mctl[3*i];
    assign ien[4+i]   = cctl[3*i+2];
    assign mhit[i]    = tick && (count == mr[i]);
    assign cap_hit[i] = (cctl[3*i] & rise[i]) | (cctl[3*i+1] & fall[i]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mr[i]                <= '0;
        cap_val[i*CW +: CW]  <= '0;
        match_out[i]         <= 1'b0;
      end else begin
        if (wr_en && wr_addr == 4'(8 + i)) mr[i] <= wr_data;
        if (cap_hit[i]) cap_val[i*CW +: CW] <= count;
        if (wr_ext) match_out[i] <= wr_data[8+i];
        else if (mhit[i]) begin
          case (oact[2*i +: 2])
            2'd1:    match_out[i] <= 1'b0;
            2'd2:    match_out[i] <= 1'b1;
            2'd3:    match_out[i] <= ~match_out[i];
            default: match_out[i] <= match_out[i];
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= '0; s2 <= '0; s3 <= '0;
    end else begin
      s1 <= cap_in; s2 <= s1; s3 <= s2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= 1'b0; hold <= 1'b0;
      mode <= '0; sel <= '0; psc <= '0;
      mctl <= '0; cctl <= '0; oact <= '0;
    end else begin
      if (wr_ctl) begin
        run  <= wr_data[0];
        hold <= wr_data[1];
      end
      if (do_stop) run <= 1'b0;
      if (wr_en && wr_addr == 4'd1) begin
        mode <= wr_data[1:0];
        sel  <= wr_data[3:2];
      end
      if (wr_en && wr_addr == 4'd2) psc  <= wr_data;
      if (wr_en && wr_addr == 4'd3) mctl <= wr_data[11:0];
      if (wr_ext)                   oact <= wr_data[7:0];
      if (wr_en && wr_addr == 4'd5) cctl <= wr_data[11:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
      pc    <= '0;
    end else if (hold) begin
      count <= '0;
      pc    <= '0;
    end else if (ev) begin
      if (tick) begin
        pc <= '0;
        if (do_rst)       count <= '0;
        else if (!do_stop) count <= count + 1'b1;
      end else begin
        pc <= pc + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= (flags & ~clr) | {cap_hit, mhit};
  end
endmodule

module pmc_timer_chk #(
  parameter int CW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [3:0]    wr_addr,
  input logic [CW-1:0] wr_data,
  input logic [CW-1:0] count,
  input logic [3:0]    match_out,
  input logic [7:0]    flags,
  input logic          run,
  input logic          hold,
  input logic          tick,
  input logic          do_stop
);
  // R2
  hold_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> count == '0);

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !hold) |=> $stable(count));

  // R3
  step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(count) |-> (count == $past(count) + 1'b1 || count == '0));

  // R6
  stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    do_stop |=> !run);

  // R8
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(flags) & ~flags)) |-> $past(wr_en && wr_addr == 4'd6));

  // R9
  ext_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(match_out) |-> $past(tick || (wr_en && wr_addr == 4'd4)));
endmodule

bind pmc_timer pmc_timer_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .count(count), .match_out(match_out), .flags(flags), .run(run), .hold(hold),
  .tick(tick), .do_stop(do_stop)
);

// File: tb/test_pmc_timer.sv
module test_pmc_timer;
  localparam int CW = 32;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [CW-1:0] wr_data = '0;
  logic [3:0] cap_in = '0;
  logic [CW-1:0] count;
  logic [4*CW-1:0] cap_val;
  logic [3:0] match_out;
  logic [7:0] flags;
  logic irq;
  int checks = 0, errors = 0;

  // prescale, match value, clock cycles, expected count
  localparam int VEC [5][4] = '{
    '{0, 9, 5, 5}, '{0, 9, 13, 3}, '{2, 100, 10, 3}, '{3, 2, 22, 2}, '{1, 4, 20, 0}};

  pmc_timer #(.CW(CW)) i_pmc_timer (.*);

  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [CW-1:0] act, input logic [CW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [CW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse3(input int n);
    for (int k = 0; k < n; k++) begin
      cap_in[3] = 1'b1; wait_n(4);
      cap_in[3] = 1'b0; wait_n(4);
    end
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait_n(2);
    rst_n = 1'b1;
    wait_n(1);
    chk("R1 count", count, 0);
    chk("R1 flags", {24'd0, flags}, 0);
    chk("R1 match_out/irq", {27'd0, match_out, irq}, 0);
    chk("R1 capture", cap_val[CW-1:0] | cap_val[2*CW-1:CW], 0);

    wr(4'd3, 32'h2);
    for (int v = 0; v < 5; v++) begin
      wr(4'd2, VEC[v][0]);
      wr(4'd8, VEC[v][1]);
      wr(4'd0, 32'h2);
      chk("R2 hold clears", count, 0);
      wr(4'd0, 32'h1);
      wait_n(VEC[v][2]);
      chk("R3 R5 prescaled count", count, VEC[v][3]);
      wr(4'd0, 32'h2);
    end

    wr(4'd2, 0);
    wr(4'd3, 32'h28);
    wr(4'd9, 20);
    wr(4'd0, 32'h1);
    wait_n(30);
    chk("R6 stop value", count, 20);
    chk("R7 match flag", {31'd0, flags[1]}, 1);
    chk("R7 irq", {31'd0, irq}, 1);
    wait_n(5);
    chk("R2 R6 stopped counter holds", count, 20);
    wr(4'd6, 0);
    chk("R8 zero write keeps flag", {31'd0, flags[1]}, 1);
    wr(4'd6, 32'h2);
    chk("R8 clear flag1", {30'd0, flags[1:0]}, 1);
    chk("R8 irq drops", {31'd0, irq}, 0);

    wr(4'd5, 32'h1D1);
    cap_in = 4'b0111;
    wait_n(4);
    chk("R10 rising cap0", cap_val[CW-1:0], 20);
    chk("R10 falling cap1 ignores rise", cap_val[2*CW-1:CW], 0);
    chk("R10 both cap2", cap_val[3*CW-1:2*CW], 20);
    chk("R10 capture flags", {29'd0, flags[6:4]}, 3'b101);
    chk("R7 capture irq", {31'd0, irq}, 1);
    wr(4'd9, 35);
    wr(4'd0, 32'h1);
    wait_n(25);
    chk("R6 second stop", count, 35);
    cap_in = 4'b0000;
    wait_n(4);
    chk("R10 cap0 ignores fall", cap_val[CW-1:0], 20);
    chk("R10 falling cap1", cap_val[2*CW-1:CW], 35);
    chk("R10 both cap2 fall", cap_val[3*CW-1:2*CW], 35);

    wr(4'd6, 32'hFF);
    wr(4'd3, 0);
    wr(4'd1, 32'hD);
    wr(4'd0, 32'h2);
    wr(4'd0, 32'h1);
    wait_n(6);
    chk("R4 clock alone does not count", count, 0);
    pulse3(5);
    chk("R4 rising edge count", count, 5);
    chk("R10 disabled channel cap3", cap_val[4*CW-1:3*CW], 0);
    chk("R10 disabled channel flag", {31'd0, flags[7]}, 0);
    wr(4'd1, 32'hF);
    wr(4'd0, 32'h2);
    wr(4'd0, 32'h1);
    pulse3(3);
    chk("R4 both edge count", count, 6);
    wr(4'd1, 32'hE);
    wr(4'd0, 32'h2);
    wr(4'd0, 32'h1);
    pulse3(3);
    chk("R4 falling edge count", count, 3);

    wr(4'd1, 0);
    wr(4'd0, 32'h2);
    wr(4'd3, 32'h2);
    wr(4'd8, 3);
    wr(4'd9, 1);
    wr(4'd10, 2);
    wr(4'd11, 0);
    wr(4'd4, 32'hC1B);
    chk("R9 initial value load", {28'd0, match_out}, 4'b1100);
    wr(4'd0, 32'h1);
    wait_n(6);
    chk("R9 output actions", {28'd0, match_out}, 4'b1011);
    chk("R5 count after wrap", count, 2);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule